// File: doc/BRIEF.md
# Multicycle Instruction-Cycle Controller

This block is a compact 16-bit processor core whose every step is sequenced by a finite state machine. Each instruction walks through six phases in a fixed order: fetch (three clocks), decode, address evaluation, operand fetch, execute and result store. An instruction that has no work in a phase still spends one clock there. The datapath holds a program counter, a memory address register, a memory data register, an instruction register, two operand latches, a result latch and eight general registers.

Memory is a single-port word store outside the block. The core drives an address from its memory address register and raises a read strobe. The store returns the word on the read-data input within the same cycle, and the memory data register captures it at the closing edge. Four operations exist: register-to-register addition, a load from a base register plus a signed 6-bit offset, an indirect jump through a register, and a stop. A run flag stands in for a gated machine clock. Reset sets it, the stop operation clears it, and while it is clear nothing in the core moves.

Top module: `ic_core`

## Requirements
- R1: After reset the phase output is 0 (first fetch step), the program counter is 0, the instruction register is 0 and the run output is 1.
- R2: In phase 0 the fetch strobe vector (bit 4 PC-to-bus gate, bit 3 address-register load, bit 2 PC load, bit 1 data-register-to-bus gate, bit 0 instruction-register load) equals 5'b11100 and no read is issued. After that clock the program counter has advanced by one.
- R3: In phase 1 the read strobe is high, the memory address equals the program counter value from before the increment, and the fetch strobe vector is 0.
- R4: In phase 2 the fetch strobe vector equals 5'b00011 and no read is issued. At phase 3 the instruction register holds the word read in phase 1.
- R5: Phases are coded fetch 0/1/2, decode 3, address 4, operand 5, execute 6, store 7 and advance one per clock in that order, returning from 7 to 0. Opcodes (bits 15:12) 0001, 0110, 1100 and 1111 run through all of them. Any other opcode goes from decode straight back to phase 0 and changes no general register.
- R6: Opcode 0001 writes the sum, modulo 2^16, of the registers selected by bits 8:6 and 2:0 into the register selected by bits 11:9.
- R7: Opcode 0110 issues a read in phase 5 at the address formed by adding the register selected by bits 8:6 to the sign-extended bits 5:0. It then writes the returned word into the register selected by bits 11:9.
- R8: Opcode 1100 loads the program counter with the register selected by bits 8:6, and the next fetch reads from that address.
- R9: Opcode 1111 clears run at the end of its execute phase. From then on the phase stays 6, the program counter holds, and the read strobe and fetch strobes stay low until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 16 | Word address to memory (memory address register) |
| mem_rd | output | 1 | Read strobe; data is taken at the end of the cycle |
| mem_rdata | input | 16 | Word returned by memory for the current address |
| run | output | 1 | Run flag; low once a stop has executed |
| pc | output | 16 | Program counter |
| ir | output | 16 | Instruction register |
| state | output | 3 | Current phase code |
| fetch_strb | output | 5 | Gate and load strobes of the fetch datapath |

## Verification
The general registers have no port of their own, so their contents can only be seen indirectly. The stimulus makes them show up on the memory address bus. A load through a base register reveals that register plus a known offset in phase 5, and a jump through a register places its value on the address of the following fetch. Short programs chain loads, an addition that wraps past 16 bits, and loads based on the sum, so every written value reaches the address bus. Negative offsets from a zero base reach the top of the address space and exercise sign extension.

// File: rtl/ic_pkg.sv
// Shared types for the instruction-cycle controller.
// Assumes the 16-bit instruction layout with the opcode in bits 15:12.
package ic_pkg;

    localparam int GPR_COUNT = 8;
    localparam int GPR_SEL_W = $clog2(GPR_COUNT);

    localparam logic [3:0] OPC_ADD  = 4'b0001;
    localparam logic [3:0] OPC_LDR  = 4'b0110;
    localparam logic [3:0] OPC_JMP  = 4'b1100;
    localparam logic [3:0] OPC_HALT = 4'b1111;

    typedef enum logic [2:0] {
        ST_FETCH_A = 3'd0,
        ST_FETCH_B = 3'd1,
        ST_FETCH_C = 3'd2,
        ST_DECODE  = 3'd3,
        ST_ADDR    = 3'd4,
        ST_OPND    = 3'd5,
        ST_EXEC    = 3'd6,
        ST_STORE   = 3'd7
    } phase_e;

    typedef struct packed {
        logic gate_pc;
        logic ld_mar;
        logic ld_pc;
        logic mem_rd;
        logic ld_mdr;
        logic gate_mdr;
        logic ld_ir;
        logic mar_ea;
        logic ld_ops;
        logic ld_res;
        logic pc_jmp;
        logic gpr_we;
        logic wb_mdr;
        logic halt;
    } ctl_t;

    function automatic logic opc_known(input logic [3:0] opc);
        return (opc == OPC_ADD) || (opc == OPC_LDR) ||
               (opc == OPC_JMP) || (opc == OPC_HALT);
    endfunction

endpackage

// File: rtl/ic_seq.sv
// Phase sequencer: walks each instruction through the fixed phase order and
// emits the datapath strobes. Holds the run flag; all strobes and the phase
// are frozen while run is low. Assumes opcode reflects the instruction register.
module ic_seq
    import ic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] opcode,
    output phase_e     phase,
    output logic       run,
    output ctl_t       ctl
);

    phase_e phase_nx;

    // Strobe decode per phase and opcode, gated by run.
    always_comb begin
        ctl = '0;
        if (run) begin
            case (phase)
                ST_FETCH_A: begin
                    ctl.gate_pc = 1'b1;
                    ctl.ld_mar  = 1'b1;
                    ctl.ld_pc   = 1'b1;
                end
                ST_FETCH_B: begin
                    ctl.mem_rd = 1'b1;
                    ctl.ld_mdr = 1'b1;
                end
                ST_FETCH_C: begin
                    ctl.gate_mdr = 1'b1;
                    ctl.ld_ir    = 1'b1;
                end
                ST_ADDR:  ctl.mar_ea = (opcode == OPC_LDR);
                ST_OPND: begin
                    ctl.mem_rd = (opcode == OPC_LDR);
                    ctl.ld_mdr = (opcode == OPC_LDR);
                    ctl.ld_ops = (opcode == OPC_ADD);
                end
                ST_EXEC: begin
                    ctl.ld_res = (opcode == OPC_ADD);
                    ctl.pc_jmp = (opcode == OPC_JMP);
                    ctl.halt   = (opcode == OPC_HALT);
                end
                ST_STORE: begin
                    ctl.gpr_we = (opcode == OPC_ADD) || (opcode == OPC_LDR);
                    ctl.wb_mdr = (opcode == OPC_LDR);
                end
                default: ctl = '0;
            endcase
        end
    end

    // Next-phase selection; decode branches on the opcode.
    always_comb begin
        phase_nx = phase;
        if (run) begin
            case (phase)
                ST_FETCH_A: phase_nx = ST_FETCH_B;
                ST_FETCH_B: phase_nx = ST_FETCH_C;
                ST_FETCH_C: phase_nx = ST_DECODE;
                ST_DECODE:  phase_nx = opc_known(opcode) ? ST_ADDR : ST_FETCH_A;
                ST_ADDR:    phase_nx = ST_OPND;
                ST_OPND:    phase_nx = ST_EXEC;
                ST_EXEC:    phase_nx = (opcode == OPC_HALT) ? ST_EXEC : ST_STORE;
                default:    phase_nx = ST_FETCH_A;
            endcase
        end
    end

    // Phase and run registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= ST_FETCH_A;
            run   <= 1'b1;
        end else begin
            phase <= phase_nx;
            if (ctl.halt) run <= 1'b0;
        end
    end

    p_fetch_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && phase == ST_FETCH_A) |=> (phase == ST_FETCH_B));

    p_decode_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && phase == ST_DECODE) |=> (phase == ST_ADDR || phase == ST_FETCH_A));

    p_halt_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && phase == ST_EXEC && opcode == OPC_HALT) |=> !run);

    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!run && $stable(phase)));

endmodule

// File: rtl/ic_regfile.sv
// General register file: two combinational read ports, one write port.
// Assumes writes are requested only in the store phase.
module ic_regfile
    import ic_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = GPR_COUNT
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [$clog2(NREG)-1:0]   wa,
    input  logic [DW-1:0]             wd,
    input  logic [$clog2(NREG)-1:0]   ra,
    input  logic [$clog2(NREG)-1:0]   rb,
    output logic [DW-1:0]             rda,
    output logic [DW-1:0]             rdb
);

    logic [DW-1:0] regs [NREG];

    assign rda = regs[ra];
    assign rdb = regs[rb];

    // Clear on reset, otherwise write the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (regs[$past(wa)] == $past(wd)));

endmodule

// File: rtl/ic_dpath.sv
// Datapath: PC with incrementer/jump mux, MAR, MDR, IR, operand and result
// latches, effective-address adder. Assumes strobes come from ic_seq.
module ic_dpath
    import ic_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctl_t          ctl,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] rda,
    input  logic [DW-1:0] rdb,
    output logic [DW-1:0] pc,
    output logic [DW-1:0] mar,
    output logic [DW-1:0] ir,
    output logic [DW-1:0] wdata
);

    localparam int OFS_W = 6;

    logic [DW-1:0] mdr, opa, opb, res, ea;

    assign ea    = rda + {{(DW-OFS_W){ir[OFS_W-1]}}, ir[OFS_W-1:0]};
    assign wdata = ctl.wb_mdr ? mdr : res;

    // Program counter: incrementer in fetch, register value on jump.
    always_ff @(posedge clk) begin
        if (!rst_n)          pc <= '0;
        else if (ctl.ld_pc)  pc <= pc + 1'b1;
        else if (ctl.pc_jmp) pc <= rda;
    end

    // Address register: PC during fetch, effective address for loads.
    always_ff @(posedge clk) begin
        if (!rst_n)                       mar <= '0;
        else if (ctl.ld_mar && ctl.gate_pc) mar <= pc;
        else if (ctl.mar_ea)              mar <= ea;
    end

    // Data and instruction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdr <= '0;
            ir  <= '0;
        end else begin
            if (ctl.ld_mdr)                mdr <= mem_rdata;
            if (ctl.ld_ir && ctl.gate_mdr) ir  <= mdr;
        end
    end

    // Operand latches and adder result for register-mode addition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa <= '0;
            opb <= '0;
            res <= '0;
        end else begin
            if (ctl.ld_ops) begin
                opa <= rda;
                opb <= rdb;
            end
            if (ctl.ld_res) res <= opa + opb;
        end
    end

    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ld_pc |=> (pc == DW'($past(pc) + 1'b1)));

    p_mar_from_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.ld_mar && ctl.gate_pc) |=> (mar == $past(pc)));

    p_ir_from_mdr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.ld_ir && ctl.gate_mdr) |=> (ir == $past(mdr)));

    p_jump_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_jmp |=> (pc == $past(rda)));

endmodule

// File: rtl/ic_core.sv
// Top of the multicycle core: sequencer, datapath and register file.
// Assumes a memory that returns mem_rdata for mem_addr within the same cycle.
module ic_core
    import ic_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [DW-1:0] mem_addr,
    output logic          mem_rd,
    input  logic [DW-1:0] mem_rdata,
    output logic          run,
    output logic [DW-1:0] pc,
    output logic [DW-1:0] ir,
    output logic [2:0]    state,
    output logic [4:0]    fetch_strb
);

    phase_e        phase;
    ctl_t          ctl;
    logic [DW-1:0] rda, rdb, wdata;

    ic_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (ir[15:12]),
        .phase  (phase),
        .run    (run),
        .ctl    (ctl)
    );

    ic_dpath #(.DW(DW)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .rda       (rda),
        .rdb       (rdb),
        .pc        (pc),
        .mar       (mem_addr),
        .ir        (ir),
        .wdata     (wdata)
    );

    ic_regfile #(.DW(DW), .NREG(GPR_COUNT)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl.gpr_we),
        .wa    (ir[11:9]),
        .wd    (wdata),
        .ra    (ir[8:6]),
        .rb    (ir[2:0]),
        .rda   (rda),
        .rdb   (rdb)
    );

    assign mem_rd     = ctl.mem_rd;
    assign state      = phase;
    assign fetch_strb = {ctl.gate_pc, ctl.ld_mar, ctl.ld_pc, ctl.gate_mdr, ctl.ld_ir};

    p_read_needs_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> run);

    p_reset_phase_r1: assert property (@(posedge clk)
        !rst_n |=> (state == 3'd0 && pc == '0 && run));

endmodule

// File: tb/tb_ic_core.sv
module tb_ic_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_rdata, pc, ir;
    logic        mem_rd, run;
    logic [2:0]  state;
    logic [4:0]  fetch_strb;
    logic [15:0] mem [256];

    int total = 0;
    int bad = 0;
    logic [15:0] op_addr;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];

    ic_core dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .run(run), .pc(pc), .ir(ir),
        .state(state), .fetch_strb(fetch_strb)
    );

    function automatic logic [15:0] enc_add(input int d, input int a, input int b);
        return {4'b0001, 3'(d), 3'(a), 3'b000, 3'(b)};
    endfunction
    function automatic logic [15:0] enc_ldr(input int d, input int b, input int ofs);
        return {4'b0110, 3'(d), 3'(b), 6'(ofs)};
    endfunction
    function automatic logic [15:0] enc_jmp(input int b);
        return {4'b1100, 3'b000, 3'(b), 6'b0};
    endfunction
    localparam logic [15:0] HALT_W = 16'hF000;

    task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Steps from phase 0 to the next phase 0 (or stop); records the phase-5 read address.
    task automatic exec_one(input string tag);
        int n = 0;
        op_addr = 16'hxxxx;
        do begin
            @(negedge clk);
            n++;
            if (mem_rd && state == 3'd5) op_addr = mem_addr;
        end while (state != 3'd0 && run && n < 40);
        check(n < 40, {tag, " instruction completes"}, 16'(n), 16'd8);
    endtask

    task automatic t_reset_state();
        clear_mem();
        mem[0] = HALT_W;
        do_reset();
        check(state == 3'd0, "R1 phase", 16'(state), 16'd0);
        check(pc == 16'h0, "R1 pc", pc, 16'h0);
        check(ir == 16'h0, "R1 ir", ir, 16'h0);
        check(run == 1'b1, "R1 run", 16'(run), 16'd1);
    endtask

    task automatic t_fetch_cycles();
        clear_mem();
        mem[0] = enc_add(1, 0, 0);
        do_reset();
        check(fetch_strb == 5'b11100, "R2 strobes phase0", 16'(fetch_strb), 16'h1c);
        check(mem_rd == 1'b0, "R2 no read phase0", 16'(mem_rd), 16'd0);
        @(negedge clk);
        check(pc == 16'h1, "R2 pc incremented", pc, 16'h1);
        check(state == 3'd1, "R3 phase", 16'(state), 16'd1);
        check(mem_rd == 1'b1, "R3 read", 16'(mem_rd), 16'd1);
        check(mem_addr == 16'h0, "R3 address", mem_addr, 16'h0);
        check(fetch_strb == 5'b00000, "R3 strobes", 16'(fetch_strb), 16'h0);
        @(negedge clk);
        check(state == 3'd2, "R4 phase", 16'(state), 16'd2);
        check(fetch_strb == 5'b00011, "R4 strobes", 16'(fetch_strb), 16'h03);
        check(mem_rd == 1'b0, "R4 no read", 16'(mem_rd), 16'd0);
        @(negedge clk);
        check(ir == mem[0], "R4 ir loaded", ir, mem[0]);
    endtask

    task automatic t_phase_order();
        clear_mem();
        mem[255] = 16'h0020;
        mem[0] = enc_ldr(1, 0, -1);
        mem[1] = 16'h2240;            // opcode 0010, targets register 1
        mem[2] = enc_ldr(2, 1, 0);
        mem[3] = HALT_W;
        do_reset();
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            check(state == 3'(i % 8), "R5 full order", 16'(state), 16'(i % 8));
        end
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            check(state == 3'(i % 4), "R5 unknown opcode short path", 16'(state), 16'(i % 4));
        end
        check(pc == 16'h2, "R5 pc after unknown", pc, 16'h2);
        exec_one("R5");
        check(op_addr == 16'h0020, "R5 unknown opcode left register", op_addr, 16'h0020);
    endtask

    task automatic t_add_ldr();
        logic [15:0] sum;
        logic [15:0] tgt;
        sum = 16'h1234 + 16'hFFF0;
        tgt = sum + 16'd5;
        clear_mem();
        mem[224] = 16'h1234;
        mem[255] = 16'hFFF0;
        mem[tgt[7:0]] = 16'h0007;
        mem[0] = enc_ldr(1, 0, -32);
        mem[1] = enc_ldr(2, 0, -1);
        mem[2] = enc_add(3, 1, 2);
        mem[3] = enc_ldr(4, 3, 5);
        mem[4] = enc_add(5, 4, 4);
        mem[5] = enc_ldr(6, 5, 0);
        mem[6] = HALT_W;
        do_reset();
        exec_one("R7");
        check(op_addr == 16'hFFE0, "R7 negative offset address", op_addr, 16'hFFE0);
        exec_one("R7");
        check(op_addr == 16'hFFFF, "R7 offset -1 address", op_addr, 16'hFFFF);
        exec_one("R6");
        exec_one("R6");
        check(op_addr == tgt, "R6 wrapped sum as base", op_addr, tgt);
        exec_one("R6");
        exec_one("R7");
        check(op_addr == 16'h000E, "R7 loaded word doubled", op_addr, 16'h000E);
    endtask

    task automatic t_jump();
        clear_mem();
        mem[255] = 16'h0030;
        mem[0] = enc_ldr(1, 0, -1);
        mem[1] = enc_jmp(1);
        mem[2] = HALT_W;
        mem[8'h30] = enc_ldr(2, 1, -16);
        mem[8'h31] = HALT_W;
        do_reset();
        exec_one("R8");
        exec_one("R8");
        check(pc == 16'h0030, "R8 pc after jump", pc, 16'h0030);
        @(negedge clk);
        check(mem_rd && mem_addr == 16'h0030, "R8 fetch at target", mem_addr, 16'h0030);
        @(negedge clk);
        @(negedge clk);
        check(ir == mem[8'h30], "R8 target word fetched", ir, mem[8'h30]);
        exec_one("R8");
        check(op_addr == 16'h0020, "R8 base from jump register", op_addr, 16'h0020);
    endtask

    task automatic t_halt();
        logic ok = 1'b1;
        clear_mem();
        mem[0] = HALT_W;
        mem[1] = enc_ldr(1, 0, 3);
        do_reset();
        exec_one("R9");
        check(run == 1'b0, "R9 run cleared", 16'(run), 16'd0);
        check(state == 3'd6, "R9 stopped in execute", 16'(state), 16'd6);
        check(pc == 16'h1, "R9 pc held", pc, 16'h1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (run || state != 3'd6 || pc != 16'h1 || mem_rd || fetch_strb != 5'b0) ok = 1'b0;
        end
        check(ok, "R9 frozen for 20 cycles", {pc[12:0], state}, {13'h1, 3'd6});
    endtask

    initial begin
        clear_mem();
        @(negedge clk);
        t_reset_state();
        t_fetch_cycles();
        t_phase_order();
        t_add_ldr();
        t_jump();
        t_halt();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=%h exp=%h", 16'h1, 16'h0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule